// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Control-Pin Mode Decoding

This block is a synthesizable behavioural model of a byte-wide one-time-programmable memory. It takes the same control inputs as such a device at its package edge: an active-low chip enable and an active-low output enable. It also takes two digital flags in place of the analog levels. One flag marks the programming voltage on the output-enable pin. The other marks the identification voltage on address line 9. From these inputs the block selects one of several modes: standby, output disable, read, signature read, program and program inhibit. It then either returns stored data, returns a fixed identification code, or writes the storage array.

The array comes out of reset erased, with every bit at one. A program cycle can only pull bits to zero: the addressed byte becomes the bitwise AND of its old value and the input byte. Outputs are registered. The block drives `dout_en` to control an external tri-state driver, and `dout` reads zero whenever that enable is low. After chip enable falls, data is held back for `VERIFY_LAT` clock edges. This models the access delay a verify read must wait out after a program pulse. The address width defaults to a small array; setting `ADDR_W` to 16 gives the full 64K x 8 organisation.

Top module: `otp_mem_ctrl`

## Requirements
- R1: After reset every byte of the array reads 0xFF, and `dout_en` and `dout` are both 0.
- R2: With `chip_en_n`=0, `out_en_n`=0, `prog_volt`=0 and `id_volt`=0, once the access delay has elapsed, each clock edge loads `dout` with the byte at `addr` and sets `dout_en`=1.
- R3: With `chip_en_n`=0, `out_en_n`=1 and `prog_volt`=0, the next edge clears `dout_en`. Lowering `out_en_n` again re-enables the output on the following edge, without a new access delay.
- R4: With `chip_en_n`=1, the next edge clears `dout_en`, and the access delay restarts from zero.
- R5: With `prog_volt`=1 and `chip_en_n`=0, each clock edge replaces the byte at `addr` with (old byte AND `din`). Bits already at zero therefore stay at zero.
- R6: With `prog_volt`=1 and `chip_en_n`=1, nothing is written and the next edge clears `dout_en`.
- R7: In a read condition with `id_volt`=1 and `addr[1]`=1, `dout` is 0x1C when `addr[0]`=0 and 0x83 when `addr[0]`=1.
- R8: In a read condition with `id_volt`=1 and `addr[1]`=0, `dout` is 0x7F regardless of `addr[0]`.
- R9: After `chip_en_n` falls in a read condition, `dout_en` stays 0 for the first `VERIFY_LAT`-1 edges and becomes 1 on edge number `VERIFY_LAT`.
- R10: Whenever `dout_en` is 0, `dout` is 0.
- R11: While `prog_volt`=1, the value of `out_en_n` has no effect: the output stays disabled in program mode even with `out_en_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array to all ones |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable |
| prog_volt | input | 1 | Programming voltage present on the output-enable pin |
| id_volt | input | 1 | Identification voltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to program |
| dout | output | DATA_W | Registered output byte, zero when disabled |
| dout_en | output | 1 | Enable for an external tri-state driver |

## Verification
The hardest case to reach is a byte that has been programmed twice with different patterns. The expected content is then the AND of both patterns, and read-back alone cannot tell it apart from a single write. The bench programs every address with one arithmetic pattern, then programs it again with a second, unrelated pattern, and reads the whole array. It also applies inhibit cycles that drive all-zero data with chip enable high, to show that they leave stored bytes unchanged. The access delay is measured edge by edge, both after reset and again after chip enable is raised and lowered.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_OUT_OFF,
        MODE_READ,
        MODE_SIGN,
        MODE_PROG,
        MODE_INHIBIT
    } otp_mode_e;

    // Programming voltage dominates: when present the output-enable pin is not a logic input.
    function automatic otp_mode_e decode_mode(
        input logic chip_en_n,
        input logic out_en_n,
        input logic prog_volt,
        input logic id_volt
    );
        otp_mode_e m;
        if (prog_volt)      m = chip_en_n ? MODE_INHIBIT : MODE_PROG;
        else if (chip_en_n) m = MODE_STANDBY;
        else if (out_en_n)  m = MODE_OUT_OFF;
        else if (id_volt)   m = MODE_SIGN;
        else                m = MODE_READ;
        return m;
    endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic      chip_en_n,
    input  logic      out_en_n,
    input  logic      prog_volt,
    input  logic      id_volt,
    output otp_mode_e mode,
    output logic      wr_en,
    output logic      rd_like
);

    always_comb begin
        mode    = decode_mode(chip_en_n, out_en_n, prog_volt, id_volt);
        wr_en   = (mode == MODE_PROG);
        rd_like = (mode == MODE_READ) || (mode == MODE_SIGN);
    end

endmodule

// File: rtl/otp_array.sv
module otp_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Reset models an erased part; writes may only clear bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en) begin
            cells[addr] <= cells[addr] & wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/otp_sig_rom.sv
module otp_sig_rom #(
    parameter int              DATA_W     = 8,
    parameter logic [DATA_W-1:0] MAKER_ID = 8'h1C,
    parameter logic [DATA_W-1:0] PART_ID  = 8'h83,
    parameter logic [DATA_W-1:0] BLANK_ID = 8'h7F
) (
    input  logic [1:0]        sel,
    output logic [DATA_W-1:0] code
);

    always_comb begin
        unique case (sel)
            2'b10:   code = MAKER_ID;
            2'b11:   code = PART_ID;
            default: code = BLANK_ID;
        endcase
    end

endmodule

// File: rtl/otp_mem_ctrl.sv
module otp_mem_ctrl
    import otp_pkg::*;
#(
    parameter int                ADDR_W     = 10,
    parameter int                DATA_W     = 8,
    parameter int                VERIFY_LAT = 3,
    parameter logic [DATA_W-1:0] MAKER_ID   = 8'h1C,
    parameter logic [DATA_W-1:0] PART_ID    = 8'h83,
    parameter logic [DATA_W-1:0] BLANK_ID   = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              prog_volt,
    input  logic              id_volt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int CNT_W = $clog2(VERIFY_LAT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(VERIFY_LAT);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] dout;
        logic              en;
    } ctrl_t;

    ctrl_t     st_d, st_q;
    otp_mode_e mode;
    logic      wr_en;
    logic      rd_like;
    logic [DATA_W-1:0] arr_rdata;
    logic [DATA_W-1:0] sig_code;

    otp_mode_decode u_dec (
        .chip_en_n (chip_en_n),
        .out_en_n  (out_en_n),
        .prog_volt (prog_volt),
        .id_volt   (id_volt),
        .mode      (mode),
        .wr_en     (wr_en),
        .rd_like   (rd_like)
    );

    otp_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (din),
        .rdata (arr_rdata)
    );

    otp_sig_rom #(
        .DATA_W   (DATA_W),
        .MAKER_ID (MAKER_ID),
        .PART_ID  (PART_ID),
        .BLANK_ID (BLANK_ID)
    ) u_sig (
        .sel  (addr[1:0]),
        .code (sig_code)
    );

    always_comb begin
        st_d = st_q;
        // Access-delay counter: runs while chip enable is low, saturates at the limit.
        if (chip_en_n) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.en   = rd_like && (st_d.cnt == CNT_MAX);
        st_d.dout = '0;
        if (st_d.en) begin
            st_d.dout = (mode == MODE_SIGN) ? sig_code : arr_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.dout;
    assign dout_en = st_q.en;

endmodule

// File: rtl/otp_mem_chk.sv
module otp_mem_chk #(
    parameter int                DATA_W     = 8,
    parameter int                VERIFY_LAT = 3,
    parameter logic [DATA_W-1:0] MAKER_ID   = 8'h1C,
    parameter logic [DATA_W-1:0] PART_ID    = 8'h83,
    parameter logic [DATA_W-1:0] BLANK_ID   = 8'h7F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en_n,
    input logic              out_en_n,
    input logic              prog_volt,
    input logic              id_volt,
    input logic [1:0]        addr_lo,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    logic sign_cond;
    assign sign_cond = !chip_en_n && !out_en_n && !prog_volt && id_volt;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0)); // R10

    AST_STANDBY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_n && !prog_volt) |=> !dout_en); // R4

    AST_OUT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en_n && out_en_n && !prog_volt) |=> !dout_en); // R3

    AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_volt && chip_en_n) |=> !dout_en); // R6

    AST_PROG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_volt && !chip_en_n) |=> !dout_en); // R11

    AST_SIGN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (sign_cond && !addr_lo[1]) |=> (!dout_en || dout == BLANK_ID)); // R8

    AST_SIGN_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (sign_cond && addr_lo[1]) |=>
            (!dout_en || dout == ($past(addr_lo[0]) ? PART_ID : MAKER_ID))); // R7

    generate
        if (VERIFY_LAT > 1) begin : g_lat
            AST_FIRST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
                (!chip_en_n && $past(chip_en_n)) |-> !dout_en); // R9
        end
    endgenerate

endmodule

bind otp_mem_ctrl otp_mem_chk #(
    .DATA_W     (DATA_W),
    .VERIFY_LAT (VERIFY_LAT),
    .MAKER_ID   (MAKER_ID),
    .PART_ID    (PART_ID),
    .BLANK_ID   (BLANK_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en_n (chip_en_n),
    .out_en_n  (out_en_n),
    .prog_volt (prog_volt),
    .id_volt   (id_volt),
    .addr_lo   (addr[1:0]),
    .dout      (dout),
    .dout_en   (dout_en)
);

// File: tb/sim_otp_mem_ctrl.sv
module sim_otp_mem_ctrl;

    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int LAT   = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chip_en_n, out_en_n, prog_volt, id_volt;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    otp_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .VERIFY_LAT(LAT)) u0 (
        .clk (clk), .rst_n (rst_n), .chip_en_n (chip_en_n), .out_en_n (out_en_n),
        .prog_volt (prog_volt), .id_volt (id_volt), .addr (addr), .din (din),
        .dout (dout), .dout_en (dout_en)
    );

    function automatic logic [7:0] pat_a(int a);
        return 8'((a * 7 + 3) ^ (a >> 3));
    endfunction

    function automatic logic [7:0] pat_b(int a);
        return 8'(~((a >> 2) ^ 8'hA5) | (a & 3));
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                finish_run();
            end
        end
    end

    initial begin
        rst_n = 1'b0; chip_en_n = 1'b1; out_en_n = 1'b1;
        prog_volt = 1'b0; id_volt = 1'b0; addr = '0; din = '0;
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 en", {7'd0, dout_en}, 8'd0);
        chk("R1 dout", dout, 8'd0);

        // R9: access delay after chip enable falls
        chip_en_n = 1'b0; out_en_n = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            tick();
            chk("R9 held", {7'd0, dout_en}, 8'd0);
            chk("R10 zero", dout, 8'd0);
        end
        tick();
        chk("R9 valid", {7'd0, dout_en}, 8'd1);
        chk("R2 erased", dout, 8'hFF);

        // R1: full sweep of the erased array
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(a);
            tick();
            chk("R1 erased", dout, 8'hFF);
        end

        // R3: output disable and immediate recovery
        out_en_n = 1'b1;
        tick();
        chk("R3 off", {7'd0, dout_en}, 8'd0);
        chk("R10 off", dout, 8'd0);
        out_en_n = 1'b0;
        tick();
        chk("R3 back", {7'd0, dout_en}, 8'd1);

        // R5, R11: two program passes, output enable held low
        prog_volt = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(a); din = pat_a(a);
            tick();
            chk("R11 prog off", {7'd0, dout_en}, 8'd0);
        end
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(a); din = pat_b(a);
            tick();
        end
        prog_volt = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(a);
            tick();
            chk("R5 and", dout, pat_a(a) & pat_b(a));
        end

        // R6: inhibit with all-zero data
        chip_en_n = 1'b1; prog_volt = 1'b1; din = '0;
        for (int a = 0; a < 64; a++) begin
            addr = AW'(a * 13);
            tick();
            chk("R6 off", {7'd0, dout_en}, 8'd0);
        end
        prog_volt = 1'b0;
        tick();
        chk("R4 off", {7'd0, dout_en}, 8'd0);
        chip_en_n = 1'b0;
        for (int k = 1; k < LAT; k++) begin
            tick();
            chk("R4 restart", {7'd0, dout_en}, 8'd0);
        end
        tick();
        chk("R4 valid", {7'd0, dout_en}, 8'd1);
        for (int a = 0; a < 64; a++) begin
            addr = AW'(a * 13);
            tick();
            chk("R6 kept", dout, pat_a(a * 13) & pat_b(a * 13));
        end

        // R7, R8: identification codes
        id_volt = 1'b1;
        for (int a = 0; a < 32; a++) begin
            addr = AW'(a * 37 + a);
            tick();
            if (addr[1]) chk("R7 code", dout, addr[0] ? 8'h83 : 8'h1C);
            else         chk("R8 blank", dout, 8'h7F);
        end
        out_en_n = 1'b1;
        tick();
        chk("R3 sign off", {7'd0, dout_en}, 8'd0);
        id_volt = 1'b0; out_en_n = 1'b0; addr = AW'(5);
        tick();
        chk("R2 read", dout, pat_a(5) & pat_b(5));

        finish_run();
    end

endmodule